// File: doc/BRIEF.md
# Paged memory window mapper

This block turns a 16-bit CPU address into a physical location in a memory system built from sixteen 16 KB RAM blocks and one 16 KB boot ROM block. The CPU space is cut into four 16 KB windows, selected by the top two address bits. The highest window is fixed on RAM block 0. The three lower windows follow one of eight preset arrangements, chosen by a 3-bit bank code that software loads through a port write. For each access the block reports the physical block number, the full physical address, a flag saying the access hits the boot ROM, and a flag saying the access falls in an unmapped hole.

After reset the lowest window is split. Reads come from the boot ROM, so the CPU can start there, and writes go to RAM. A write to a second port turns the ROM off for good, until the next reset. From then on, reads of the lowest window follow the bank code as well. The mapping is combinational from two registers, so a port write changes the mapping from the next clock cycle on. Memory arrays and bus timing belong to the surrounding logic.

Top module: `page_window_mapper`

## Requirements
- R1: Addresses with cpu_addr[15:14] = 2'b11 always give phys_block 0, rom_sel 0 and open_bus 0, for every bank code and ROM state, for both reads and writes.
- R2: For bank codes n = 0 to 4, windows 0, 1 and 2 (cpu_addr[15:14] = 0, 1, 2) map to blocks 3n+1, 3n+2 and 3n+3.
- R3: Bank code 5 maps windows 0, 1 and 2 to blocks 1, 2 and 13. Bank code 7 maps them to blocks 1, 4 and 13.
- R4: Bank code 6 maps window 0 to block 14 and window 1 to block 15. Window 2 is a hole. Any access to it gives open_bus 1, phys_block 0 and rom_sel 0.
- R5: After a synchronous active-low reset, the bank code is 0 and the ROM is enabled. A window 0 read gives phys_block 16 with rom_sel 1. A window 0 write gives block 1. Window 1 gives block 2 and window 2 gives block 3.
- R6: A port write with port_sel = 1 sets a sticky ROM-off flag, whatever the data. From then on, window 0 reads follow the bank code with rom_sel 0. Only reset clears the flag.
- R7: While the ROM is enabled, window 0 reads stay on block 16 with rom_sel 1 for every bank code. Window 0 writes, and windows 1 and 2, follow the bank code.
- R8: A port write with port_sel = 0 loads the bank code from port_data[2:0]. Bits 7:3 are ignored.
- R9: phys_addr equals {phys_block, cpu_addr[13:0]}. rom_sel is 1 only for window 0 reads while the ROM is enabled.
- R10: A register write changes the mapping starting on the cycle after its clock edge. An access in the same cycle as the write uses the old mapping. The bank code does not change without a bank port write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_wr | input | 1 | Port write strobe, one cycle |
| port_sel | input | 1 | 0 = bank code register, 1 = ROM-off port |
| port_data | input | 8 | Port write data |
| cpu_addr | input | 16 | CPU address of the current access |
| cpu_wr | input | 1 | 1 = write access, 0 = read access |
| phys_block | output | 5 | Physical block number (16 = boot ROM) |
| phys_addr | output | 19 | Physical byte address |
| rom_sel | output | 1 | Access hits the boot ROM |
| open_bus | output | 1 | Access falls in an unmapped hole |

## Verification
Two things can happen in the same cycle: a register write, which is a bank code load or a ROM turn-off, and a CPU access to the window that this write is about to remap. The bench provokes this on purpose. It presents a window 0 read, or a window 2 access, in the same cycle as the port strobe. The reference model judges that access against the state before the edge, and the next access against the state after it. Every bank code is run with the ROM enabled and again with it disabled. High data bits are set on code loads, and the ROM is re-enabled by a mid-run reset.

// File: rtl/pwm_pkg.sv
// Shared definitions for the paged memory window mapper.
// Assumes a single port-select bit that picks one of two write targets.
package pwm_pkg;
    typedef enum logic {
        SEL_BANK   = 1'b0,
        SEL_ROMOFF = 1'b1
    } port_sel_e;

    localparam int LINEAR_CODES = 5;   // codes below this follow 3n+1.. arithmetic
    localparam int CODE_SPLIT   = 5;   // preset arrangement, shared low blocks
    localparam int CODE_HOLE    = 6;   // arrangement with an unmapped window
    localparam int CODE_ALT     = 7;   // preset arrangement, alternate middle block
endpackage

// File: rtl/pwm_ctrl_regs.sv
// Control registers of the window mapper: the bank code and the sticky ROM-off flag.
// Assumes one write strobe per cycle, targeted by port_sel; synchronous active-low reset.
module pwm_ctrl_regs
    import pwm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_wr,
    input  logic              port_sel,
    input  logic [DATA_W-1:0] port_data,
    output logic [CODE_W-1:0] bank_code,
    output logic              rom_off
);
    logic unused_hi_bits;
    assign unused_hi_bits = ^port_data[DATA_W-1:CODE_W];

    // Bank code register: loads only the low code bits on a bank port write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_code <= '0;
        else if (port_wr && port_sel == SEL_BANK)
            bank_code <= port_data[CODE_W-1:0];
    end

    // ROM-off flag: set by any ROM-off port write, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rom_off <= 1'b0;
        else if (port_wr && port_sel == SEL_ROMOFF)
            rom_off <= 1'b1;
    end

    // R6: once set, the flag stays set until reset
    p_rom_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rom_off |=> rom_off);
    // R6: a ROM-off port write always leaves the flag set
    p_rom_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && port_sel == SEL_ROMOFF) |=> rom_off);
    // R8: a bank write loads exactly the low data bits
    p_code_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && port_sel == SEL_BANK) |=> bank_code == $past(port_data[CODE_W-1:0]));
    // R10: without a bank write the code holds
    p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_wr && port_sel == SEL_BANK) |=> $stable(bank_code));
endmodule

// File: rtl/pwm_bank_table.sv
// Preset arrangement table: gives, for a bank code, the RAM block of every window
// and whether the window is a hole. The last window is fixed on FIXED_BLOCK.
// Assumes NWIN windows, of which the lower NWIN-1 are banked.
module pwm_bank_table
    import pwm_pkg::*;
#(
    parameter int CODE_W      = 3,
    parameter int BLK_W       = 5,
    parameter int NWIN        = 4,
    parameter int FIXED_BLOCK = 0
) (
    input  logic [CODE_W-1:0]           code,
    output logic [NWIN-1:0][BLK_W-1:0] blk,
    output logic [NWIN-1:0]             hole
);
    localparam int NBANKED = NWIN - 1;

    localparam logic [BLK_W-1:0] SPLIT_TAB [3] = '{BLK_W'(1),  BLK_W'(2),  BLK_W'(13)};
    localparam logic [BLK_W-1:0] HOLE_TAB  [3] = '{BLK_W'(14), BLK_W'(15), BLK_W'(0)};
    localparam logic [BLK_W-1:0] ALT_TAB   [3] = '{BLK_W'(1),  BLK_W'(4),  BLK_W'(13)};

    for (genvar gw = 0; gw < NWIN; gw++) begin : g_win
        if (gw == NWIN - 1) begin : g_fixed
            // Fixed window: independent of the bank code.
            always_comb begin
                blk[gw]  = BLK_W'(FIXED_BLOCK);
                hole[gw] = 1'b0;
            end
        end else begin : g_banked
            // Banked window: arithmetic for the linear codes, presets for the rest.
            always_comb begin
                hole[gw] = 1'b0;
                blk[gw]  = BLK_W'(int'(code) * NBANKED + gw + 1);
                if (int'(code) >= LINEAR_CODES) begin
                    case (int'(code))
                        CODE_SPLIT: blk[gw] = SPLIT_TAB[gw];
                        CODE_HOLE: begin
                            blk[gw]  = HOLE_TAB[gw];
                            hole[gw] = (gw == NBANKED - 1);
                        end
                        default:   blk[gw] = ALT_TAB[gw];
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/page_window_mapper.sv
// Paged memory window mapper top: splits the CPU address into window and offset,
// picks ROM or the banked RAM block, and forms the physical address.
// Assumes cpu_addr and cpu_wr are stable for the cycle; mapping is combinational
// from registered state, so port writes take effect on the following cycle.
module page_window_mapper
    import pwm_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WIN_W     = 2,
    parameter int DATA_W    = 8,
    parameter int CODE_W    = 3,
    parameter int BLK_W     = 5,
    parameter int ROM_BLOCK = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       port_wr,
    input  logic                       port_sel,
    input  logic [DATA_W-1:0]          port_data,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic                       cpu_wr,
    output logic [BLK_W-1:0]           phys_block,
    output logic [BLK_W+ADDR_W-WIN_W-1:0] phys_addr,
    output logic                       rom_sel,
    output logic                       open_bus
);
    localparam int OFF_W = ADDR_W - WIN_W;
    localparam int NWIN  = 1 << WIN_W;

    logic [CODE_W-1:0]          bank_code;
    logic                       rom_off;
    logic [NWIN-1:0][BLK_W-1:0] tab_blk;
    logic [NWIN-1:0]            tab_hole;
    logic [WIN_W-1:0]           win;

    pwm_ctrl_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_wr   (port_wr),
        .port_sel  (port_sel),
        .port_data (port_data),
        .bank_code (bank_code),
        .rom_off   (rom_off)
    );

    pwm_bank_table #(.CODE_W(CODE_W), .BLK_W(BLK_W), .NWIN(NWIN), .FIXED_BLOCK(0)) u_tab (
        .code (bank_code),
        .blk  (tab_blk),
        .hole (tab_hole)
    );

    assign win = cpu_addr[ADDR_W-1:OFF_W];

    // Window select: boot ROM for low-window reads while enabled, else the table.
    always_comb begin
        if (win == '0 && !cpu_wr && !rom_off) begin
            phys_block = BLK_W'(ROM_BLOCK);
            rom_sel    = 1'b1;
            open_bus   = 1'b0;
        end else begin
            phys_block = tab_blk[win];
            rom_sel    = 1'b0;
            open_bus   = tab_hole[win];
        end
    end

    // Physical address: block number above the in-window offset.
    assign phys_addr = {phys_block, cpu_addr[OFF_W-1:0]};

    // R1: the top window is always RAM block 0
    p_top_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (win == WIN_W'(NWIN - 1)) |-> (phys_block == '0 && !rom_sel && !open_bus));
    // R4: a hole only appears for code 6, window 2
    p_hole_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        open_bus |-> (int'(bank_code) == CODE_HOLE && win == WIN_W'(2) && !rom_sel));
    // R7: low-window reads stay on ROM while it is enabled
    p_rom_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_off && win == '0 && !cpu_wr) |-> (rom_sel && phys_block == BLK_W'(ROM_BLOCK)));
    // R9: writes never select the ROM
    p_wr_no_rom_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |-> !rom_sel);
endmodule

// File: tb/page_window_mapper_tb.sv
module page_window_mapper_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_wr = 1'b0;
    logic        port_sel = 1'b0;
    logic [7:0]  port_data = '0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [4:0]  phys_block;
    logic [18:0] phys_addr;
    logic        rom_sel;
    logic        open_bus;

    int vectors = 0;
    int miscompares = 0;

    // reference model state
    int  m_code = 0;
    bit  m_romoff = 0;

    page_window_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_sel(port_sel),
        .port_data(port_data), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .phys_block(phys_block), .phys_addr(phys_addr),
        .rom_sel(rom_sel), .open_bus(open_bus)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // expected mapping from the requirements
    function automatic void expect_map(input int code, input bit romoff, input int w,
                                       input bit wr, output int blk, output bit rs,
                                       output bit ob);
        int t5[3] = '{1, 2, 13};
        int t7[3] = '{1, 4, 13};
        rs = 0; ob = 0;
        if (w == 3) blk = 0;                               // R1
        else if (w == 0 && !wr && !romoff) begin blk = 16; rs = 1; end // R5 R7
        else if (code <= 4) blk = 3 * code + w + 1;        // R2
        else if (code == 5) blk = t5[w];                   // R3
        else if (code == 7) blk = t7[w];                   // R3
        else begin                                         // R4
            if (w == 0) blk = 14;
            else if (w == 1) blk = 15;
            else begin blk = 0; ob = 1; end
        end
    endfunction

    // one cycle: drive at negedge, compare before the edge, update model at the edge
    task automatic step(input string req, input bit rst, input bit pw, input bit ps,
                        input logic [7:0] pd, input logic [15:0] a, input bit wr);
        int eb; bit ers, eob;
        @(negedge clk);
        rst_n = rst; port_wr = pw; port_sel = ps; port_data = pd;
        cpu_addr = a; cpu_wr = wr;
        #1;
        if (rst) begin
            expect_map(m_code, m_romoff, int'(a[15:14]), wr, eb, ers, eob);
            vectors++;
            if (int'(phys_block) != eb || rom_sel != ers || open_bus != eob ||
                phys_addr != {5'(eb), a[13:0]}) begin
                miscompares++;
                $display("FAIL %s: addr=%h wr=%0d got blk=%0d rom=%0b ob=%0b pa=%h exp blk=%0d rom=%0b ob=%0b pa=%h",
                         req, a, wr, phys_block, rom_sel, open_bus, phys_addr,
                         eb, ers, eob, {5'(eb), a[13:0]});
            end
        end
        @(posedge clk);
        if (!rst) begin m_code = 0; m_romoff = 0; end
        else if (pw && !ps) m_code = int'(pd[2:0]);
        else if (pw && ps) m_romoff = 1;
    endtask

    task automatic sweep(input string req, input logic [13:0] off);
        for (int w = 0; w < 4; w++) begin
            step(req, 1, 0, 0, 8'h00, {2'(w), off}, 1'b0);
            step(req, 1, 0, 0, 8'h00, {2'(w), off ^ 14'h2a5c}, 1'b1);
        end
    endtask

    initial begin
        fork
            begin
                // reset, then R5 reset mapping
                step("R5", 0, 0, 0, 8'h00, 16'h0000, 0);
                step("R5", 0, 0, 0, 8'h00, 16'h0000, 0);
                sweep("R5", 14'h0123);
                // every code with ROM enabled: R2 R3 R4 R7 R8 (high bits set)
                for (int c = 0; c < 8; c++) begin
                    step("R8", 1, 1, 0, {5'b10110, 3'(c)}, 16'h0010, 0);
                    sweep(c < 5 ? "R2_R7" : (c == 6 ? "R4_R7" : "R3_R7"), 14'(c * 977));
                end
                // same-cycle: ROM-off write while reading window 0 (R10 old mapping)
                step("R10", 1, 1, 0, 8'h02, 16'h0000, 0);
                step("R10", 1, 1, 1, 8'h00, 16'h1234, 0);
                step("R6", 1, 0, 0, 8'h00, 16'h1234, 0);
                // every code with ROM disabled: R1 R2 R3 R4 R9
                for (int c = 7; c >= 0; c--) begin
                    step("R8", 1, 1, 0, {5'b01001, 3'(c)}, 16'h8000, 1);
                    sweep(c < 5 ? "R2_R9" : (c == 6 ? "R4_R1" : "R3_R1"), 14'(c * 1511 + 7));
                end
                // same-cycle: bank write while accessing window 2 (R10)
                step("R10", 1, 1, 0, 8'h06, 16'h8abc, 0);
                step("R10", 1, 1, 0, 8'h03, 16'h8abc, 1);
                step("R10", 1, 0, 0, 8'h00, 16'h8abc, 1);
                // further ROM-off writes with data keep it off (R6)
                step("R6", 1, 1, 1, 8'hff, 16'h0042, 0);
                step("R6", 1, 0, 0, 8'h00, 16'h0042, 0);
                // reset re-enables ROM and clears code (R5 R6)
                step("R5", 0, 0, 0, 8'h00, 16'h0000, 0);
                sweep("R5_R6", 14'h3fff);
                // ROM-off with bank code preloaded, boundary offsets (R9)
                step("R8", 1, 1, 0, 8'hfd, 16'hffff, 1);
                step("R6", 1, 1, 1, 8'h00, 16'h0000, 0);
                sweep("R9", 14'h0000);
                sweep("R9", 14'h3fff);
            end
            begin
                repeat (5000) @(posedge clk);
                miscompares++;
                $display("FAIL watchdog: run did not finish, got timeout exp completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule